// File: doc/BRIEF.md
# Bit-Slip Receive Word Aligner

This block sits behind an 8-bit deserializer and lets an external controller find the word boundary of a serial stream. Each clock it takes one parallel word. A rising edge on the slip request moves the boundary one bit later in the stream. The controller watches the realigned words and the pattern-detect pulse, and it keeps slipping until the programmed 16-bit alignment pattern appears across two consecutive realigned words.

The slip request passes through a two-state edge machine. In `SLIP_LOW`, a high request moves the machine to `SLIP_HIGH` and emits one slip pulse. This is the `ARM` transition. In `SLIP_HIGH`, a low request moves the machine back to `SLIP_LOW` with no pulse. This is the `REARM` transition. In every other case the machine stays in its current state with no pulse. Each slip pulse advances a 3-bit offset counter. The offset picks 8 bits out of a 16-bit history of the two most recent input words. A matcher compares the last two realigned words with the pattern and registers the result.

The stream is taken as most significant bit first, so bit 7 of a word arrives before bit 0.

Top module: `slip_word_aligner`

## Requirements
- R1: The realigned word is 8 bits wide. It is taken from a 16-bit history: the older input word sits in bits 15..8 and the newer input word in bits 7..0. At offset 0 the output equals the older input word.
- R2: A slip takes place only when the slip request is high in a cycle and was low in the previous cycle. Holding the request high causes no further slips.
- R3: At offset k the output word is history bits [15-k : 8-k]. Each slip therefore moves the boundary one bit later in the stream.
- R4: The offset counts modulo 8. After eight slips the output is aligned to the original boundary again.
- R5: The output word registered on the clock edge that samples a rising slip request already uses the new offset.
- R6: The detect output is high for one cycle when the value formed by the previous output word (upper byte) and the current output word (lower byte) equals the pattern. The result is registered, so it appears one cycle after that pair of words is present.
- R7: The 16-bit pattern is an input and can change at run time. The compare always uses its present value.
- R8: A synchronous active-high reset clears the offset, the history, the previous realigned word, the edge state and the detect output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel word clock |
| rst_i | input | 1 | Synchronous active-high reset |
| data_i | input | 8 | Received parallel word |
| slip_i | input | 1 | Slip request, acted on at its rising edge |
| pattern_i | input | 16 | Alignment pattern; the older word is in the upper byte |
| word_o | output | 8 | Realigned word |
| detect_o | output | 1 | One-cycle pattern-detect pulse |
| slip_off_o | output | 3 | Current slip offset |

## Verification
The bench builds the block with its default 8-bit word, which gives a 16-bit pattern and a 3-bit offset. At this size the bench can walk through all eight offsets in a short run, including the wrap from 7 back to 0. It places the pattern at offsets 0, 3 and 7 by feeding a bit-shifted stream, then checks that the pattern is detected only after the matching number of slips. Short and long slip pulses are mixed so that holding the request high is shown to have no effect.

// File: rtl/swa_pkg.sv
package swa_pkg;
    typedef enum logic {
        SLIP_LOW  = 1'b0,
        SLIP_HIGH = 1'b1
    } slip_state_e;
endpackage

// File: rtl/swa_slip_fsm.sv
module swa_slip_fsm
    import swa_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic slip_i,
    output logic pulse_o
);
    slip_state_e state_q, state_d;

    // Next-state logic: ARM and REARM transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLIP_LOW:  if (slip_i)  state_d = SLIP_HIGH;
            SLIP_HIGH: if (!slip_i) state_d = SLIP_LOW;
            default:   state_d = SLIP_LOW;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= SLIP_LOW;
        else       state_q <= state_d;
    end

    // Output logic: one pulse per ARM transition.
    always_comb begin
        pulse_o = 1'b0;
        unique case (state_q)
            SLIP_LOW:  pulse_o = slip_i;
            SLIP_HIGH: pulse_o = 1'b0;
            default:   pulse_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/swa_offset_ctr.sv
module swa_offset_ctr #(
    parameter int DW   = 8,
    localparam int OFFW = $clog2(DW)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            step_i,
    output logic [OFFW-1:0] off_o
);
    localparam logic [OFFW-1:0] OFF_LAST = OFFW'(DW - 1);

    logic [OFFW-1:0] off_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            off_q <= '0;
        else if (step_i)
            off_q <= (off_q == OFF_LAST) ? '0 : off_q + 1'b1;
    end

    assign off_o = off_q;
endmodule

// File: rtl/swa_realign.sv
module swa_realign #(
    parameter int DW   = 8,
    localparam int OFFW = $clog2(DW),
    localparam int HW   = 2 * DW
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [DW-1:0]   data_i,
    input  logic [OFFW-1:0] off_i,
    output logic [DW-1:0]   word_o
);
    logic [HW-1:0] hist_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) hist_q <= '0;
        else       hist_q <= {hist_q[DW-1:0], data_i};
    end

    // Each output bit is one wide mux over the history window.
    for (genvar gi = 0; gi < DW; gi++) begin : g_bit
        always_comb begin
            word_o[gi] = hist_q[DW + gi - int'(off_i)];
        end
    end
endmodule

// File: rtl/swa_matcher.sv
module swa_matcher #(
    parameter int DW  = 8,
    localparam int PW = 2 * DW
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [DW-1:0] word_i,
    input  logic [PW-1:0] pattern_i,
    output logic          detect_o
);
    logic [DW-1:0] prev_q;
    logic          det_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= '0;
            det_q  <= 1'b0;
        end else begin
            prev_q <= word_i;
            det_q  <= ({prev_q, word_i} == pattern_i);
        end
    end

    assign detect_o = det_q;
endmodule

// File: rtl/slip_word_aligner.sv
module slip_word_aligner #(
    parameter int DW   = 8,
    localparam int OFFW = $clog2(DW),
    localparam int PW   = 2 * DW
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [DW-1:0]   data_i,
    input  logic            slip_i,
    input  logic [PW-1:0]   pattern_i,
    output logic [DW-1:0]   word_o,
    output logic            detect_o,
    output logic [OFFW-1:0] slip_off_o
);
    logic            slip_pulse;
    logic [OFFW-1:0] off;

    swa_slip_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .slip_i  (slip_i),
        .pulse_o (slip_pulse)
    );

    swa_offset_ctr #(.DW(DW)) u_ctr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .step_i (slip_pulse),
        .off_o  (off)
    );

    swa_realign #(.DW(DW)) u_realign (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .data_i (data_i),
        .off_i  (off),
        .word_o (word_o)
    );

    swa_matcher #(.DW(DW)) u_match (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .word_i    (word_o),
        .pattern_i (pattern_i),
        .detect_o  (detect_o)
    );

    assign slip_off_o = off;
endmodule

// File: rtl/swa_checker.sv
module swa_checker #(
    parameter int DW   = 8,
    localparam int OFFW = $clog2(DW),
    localparam int PW   = 2 * DW
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            slip_i,
    input logic [DW-1:0]   word_o,
    input logic            detect_o,
    input logic [PW-1:0]   pattern_i,
    input logic [OFFW-1:0] off
);
    localparam logic [OFFW-1:0] OFF_LAST = OFFW'(DW - 1);

    // R2: a request held high gives no further slip
    a_r2_held_no_slip: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(rst_i, 2) && $past(slip_i) && $past(slip_i, 2))
        |-> (off == $past(off)));

    // R4 and R5: a rising request steps the offset once, wrapping modulo DW
    a_r5_step_on_edge: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(rst_i, 2) && $past(slip_i) && !$past(slip_i, 2))
        |-> (off == (($past(off) == OFF_LAST) ? '0 : $past(off) + 1'b1)));

    // R4: the offset never leaves 0..DW-1
    a_r4_offset_range: assert property (@(posedge clk_i) disable iff (rst_i)
        (int'(off) < DW));

    // R6: detect reflects the pair of words seen one cycle earlier
    a_r6_detect_pair: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(rst_i, 2) && !$past(rst_i, 3))
        |-> (detect_o == ({$past(word_o, 2), $past(word_o)} == $past(pattern_i))));

    // R8: reset clears the offset, the word and the detect output
    a_r8_reset_clear: assert property (@(posedge clk_i)
        $past(rst_i) |-> (off == '0 && word_o == '0 && !detect_o));
endmodule

bind slip_word_aligner swa_checker #(.DW(DW)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .slip_i    (slip_i),
    .word_o    (word_o),
    .detect_o  (detect_o),
    .pattern_i (pattern_i),
    .off       (slip_off_o)
);

// File: tb/slip_word_aligner_bench.sv
module slip_word_aligner_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  din = '0;
    logic        slip = 1'b0;
    logic [15:0] pat = 16'hA53C;
    logic [7:0]  word;
    logic        det;
    logic [2:0]  offo;

    always #(CLK_PERIOD/2) clk = ~clk;

    slip_word_aligner u_slip_word_aligner (
        .clk_i(clk), .rst_i(rst), .data_i(din), .slip_i(slip),
        .pattern_i(pat), .word_o(word), .detect_o(det), .slip_off_o(offo)
    );

    typedef struct {
        logic [7:0] w;
        logic       d;
        logic [2:0] o;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int det_seen = 0;

    // Reference state, computed from the requirements.
    logic [15:0] m_hist = '0;
    logic [2:0]  m_off = '0;
    logic        m_sprev = 1'b0;
    logic [7:0]  m_wa = '0, m_wb = '0;

    task automatic step(input logic [7:0] d, input logic s, input logic r, input string tag);
        exp_t e;
        logic edge_s;
        @(negedge clk);
        din = d; slip = s; rst = r;
        @(posedge clk);
        if (r) begin
            m_hist = '0; m_off = '0; m_sprev = 1'b0; m_wa = '0; m_wb = '0;
            e.w = '0; e.d = 1'b0;
        end else begin
            edge_s = s && !m_sprev;
            m_sprev = s;
            e.d = ({m_wb, m_wa} == pat);
            if (edge_s) m_off = m_off + 3'd1;
            m_hist = {m_hist[7:0], d};
            e.w = 8'(m_hist >> (8 - m_off));
            m_wb = m_wa;
            m_wa = e.w;
        end
        e.o = m_off;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare design outputs against queued expectations.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (det) det_seen++;
            if (word !== e.w || det !== e.d || offo !== e.o) begin
                errors++;
                $display("FAIL %s word=%h det=%b off=%0d expected word=%h det=%b off=%0d",
                         e.tag, word, det, offo, e.w, e.d, e.o);
            end
        end
    end

    // Feed pattern so that it aligns after k slips.
    task automatic feed_pattern(input int k, input string tag);
        logic [31:0] y;
        y = {8'h00, pat, 8'h00} >> k;
        step(y[31:24], 1'b0, 1'b0, tag);
        step(y[23:16], 1'b0, 1'b0, tag);
        step(y[15:8],  1'b0, 1'b0, tag);
        step(y[7:0],   1'b0, 1'b0, tag);
        step(8'h00,    1'b0, 1'b0, tag);
        step(8'h00,    1'b0, 1'b0, tag);
    endtask

    task automatic slips(input int n, input int hold, input string tag);
        for (int i = 0; i < n; i++) begin
            for (int h = 0; h < hold; h++) step(8'h5A ^ 8'(i + h), 1'b1, 1'b0, tag);
            step(8'h0F, 1'b0, 1'b0, tag);
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int d0;
        // R8: reset state
        step(8'hFF, 1'b1, 1'b1, "R8_reset");
        step(8'hFF, 1'b1, 1'b1, "R8_reset");
        // R1: plain words at offset 0
        for (int i = 0; i < 6; i++) step(8'(i * 37 + 3), 1'b0, 1'b0, "R1_passthrough");
        // R6: pattern at offset 0
        d0 = det_seen;
        feed_pattern(0, "R6_detect_off0");
        repeat (2) @(negedge clk);
        checks++;
        if (det_seen == d0) begin errors++; $display("FAIL R6 no detect at offset 0, actual 0 expected >0"); end
        // R2: long held requests produce one slip each
        slips(3, 5, "R2_held_slip");
        // R3/R5: single-cycle requests, word checked right after each
        slips(2, 1, "R3_R5_single_slip");
        // R4: walk to wrap (total 5 so far, 3 more -> 0)
        slips(3, 2, "R4_wrap");
        feed_pattern(0, "R4_realigned_after_wrap");
        // Pattern at offset 3 found only after three slips
        slips(3, 1, "R3_to_offset3");
        d0 = det_seen;
        feed_pattern(3, "R3_detect_off3");
        repeat (2) @(negedge clk);
        checks++;
        if (det_seen == d0) begin errors++; $display("FAIL R3 no detect at offset 3, actual 0 expected >0"); end
        // R7: new pattern at run time
        pat = 16'h1EC7;
        slips(4, 3, "R7_to_offset7");
        d0 = det_seen;
        feed_pattern(7, "R7_new_pattern_off7");
        repeat (2) @(negedge clk);
        checks++;
        if (det_seen == d0) begin errors++; $display("FAIL R7 no detect with new pattern, actual 0 expected >0"); end
        // R8: reset in mid-run with a nonzero offset and slip held high
        step(8'h99, 1'b1, 1'b1, "R8_midrun_reset");
        step(8'h66, 1'b1, 1'b0, "R8_after_reset");
        step(8'h33, 1'b1, 1'b0, "R8_after_reset");
        for (int i = 0; i < 10; i++) step(8'(i * 91), 1'(i % 3 == 0), 1'b0, "R2_R3_mixed");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule